// File: doc/BRIEF.md
# Fast Ethernet Repeater Core State Machine

This block is the central controller of a multi-port 100 Mb/s repeater. Each clock it counts the ports that are carrying receive activity, plus activity announced by other cascaded repeater chips. From that count it moves between five states: idle, single-source repeat, collision, one-port-left and noise. A port that is jabbering or partitioned is removed from the count before any decision is made. It gives a receive enable to the one port it listens to and transmit enables to the ports it drives. It also tells the transmit path which nibble source to use: repeated data, a jam pattern or a regenerated preamble. In jam and preamble cases it supplies the nibble itself.

The data FIFO that re-times received nibbles lives outside this block, and so do the per-port jabber and partition monitors. Only their flags enter here. The cascade bus logic that merges activity and collision across chips is also outside; it provides one activity bit and one collision bit.

Top module: `repeater_core`

## Requirements
- R1: After reset the state code is 0 (idle), no transmit enable is set, the source select is 0 (none) and the nibble is 0. The state codes are idle=0, collision=1, one-port-left=2, repeat=3, noise=4.
- R2: From idle, when exactly one source is active, the next state is repeat (3). The index of that port N is latched on entry and held until idle. Every port except N is transmit-enabled. If the source is the cascade input, all ports are enabled. The source select is 1 (data).
- R3: When more than one source is active, or the cascade collision input is high, the state becomes collision (1) from idle, repeat, one-port-left or noise. Collision enables every port, including N, and selects jam (2).
- R4: Collision goes to idle when no source is active and the cascade collision input is low. It goes to one-port-left when exactly one source remains and the cascade collision input is low. Otherwise it stays in collision.
- R5: One-port-left (2) transmits jam on every port except the remaining active port, which is latched on entry. It returns to collision if another source becomes active. It goes to idle when activity ends.
- R6: In repeat, an elasticity-buffer error without a collision moves the machine to noise (4). Noise transmits jam on all ports. It leaves to collision on a collision, or to idle when no source is active.
- R7: The raw receive enable is one-hot on port N in repeat and zero in all other states. The output polarity comes from `rxe_pol_pin`, sampled on clock edges while reset is held. A value of 1 means active-high. A value of 0 means every `rx_en` bit is the inverse of the raw value.
- R8: Ports with `jabber` or `partition` set are ignored as sources. A port with `jabber` set also has its transmit enable forced low.
- R9: Jam nibbles alternate 3, 4, 3, 4, …, starting with 3 in the first cycle that jam is selected, for as long as jam stays selected.
- R10: With `preamble_mode` high, the source select is 0 for the first PRE_DELAY cycles after leaving idle. The select then becomes 3 (preamble) for PRE_LEN cycles of nibble 5 followed by one nibble D. This full sequence runs even if a collision arrives during it. After that the source follows the state.
- R11: `tx_ready` is high exactly when some transmit enable is high. `tx_sel` uses 0=none, 1=data, 2=jam, 3=preamble. `tx_nibble` is 0 when the select is none or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxe_pol_pin | input | 1 | Receive-enable polarity strap, sampled during reset |
| preamble_mode | input | 1 | Enables preamble regeneration |
| carrier | input | NPORTS | Per-port carrier sense |
| jabber | input | NPORTS | Per-port jabber flag |
| partition | input | NPORTS | Per-port partition flag |
| casc_active | input | 1 | Activity reported by other cascaded chips |
| casc_col | input | 1 | Collision reported by other cascaded chips |
| eb_error | input | 1 | Elasticity-buffer overflow or underflow |
| rx_en | output | NPORTS | Per-port receive enable, polarity applied |
| tx_en | output | NPORTS | Per-port transmit enable |
| tx_ready | output | 1 | High when any transmit enable is high |
| state_code | output | 4 | Current state code |
| tx_sel | output | 2 | Transmit nibble source select |
| tx_nibble | output | 4 | Jam or preamble nibble |

## Verification
The bench builds the block with NPORTS=4, PRE_DELAY=12 and PRE_LEN=15. With only four ports, random carrier patterns regularly produce every transition: overlaps into collision, drop-back into one-port-left and single-source repeats. Keeping the default preamble timing means the 12-cycle wait and the 16-nibble regeneration are checked at their real lengths. Those runs include a collision landing in the middle of the preamble.

// File: rtl/repeater_core.sv
module repeater_core #(
  parameter int NPORTS    = 8,
  parameter int PRE_DELAY = 12,
  parameter int PRE_LEN   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxe_pol_pin,
  input  logic              preamble_mode,
  input  logic [NPORTS-1:0] carrier,
  input  logic [NPORTS-1:0] jabber,
  input  logic [NPORTS-1:0] partition,
  input  logic              casc_active,
  input  logic              casc_col,
  input  logic              eb_error,
  output logic [NPORTS-1:0] rx_en,
  output logic [NPORTS-1:0] tx_en,
  output logic              tx_ready,
  output logic [3:0]        state_code,
  output logic [1:0]        tx_sel,
  output logic [3:0]        tx_nibble
);

  localparam int IW  = $clog2(NPORTS + 1);
  localparam int CW  = $clog2(PRE_DELAY + PRE_LEN + 2);
  localparam logic [IW-1:0] EXT = IW'(NPORTS);

  typedef enum logic [3:0] {
    S_IDLE  = 4'd0,
    S_COLL  = 4'd1,
    S_OPL   = 4'd2,
    S_RPT   = 4'd3,
    S_NOISE = 4'd4
  } state_t;

  localparam logic [1:0] P_WAIT = 2'd0, P_RUN = 2'd1, P_DONE = 2'd2;
  localparam logic [1:0] SRC_NONE = 2'd0, SRC_DATA = 2'd1, SRC_JAM = 2'd2, SRC_PRE = 2'd3;

  state_t            state_q, state_d;
  logic [IW-1:0]     n_q, left_q, sole;
  logic              pol_q, jam_q;
  logic [1:0]        phase_q;
  logic [CW-1:0]     pcnt_q;
  logic [NPORTS-1:0] act, rx_raw;
  logic [IW:0]       srcs;
  logic              coll, one, none;

  function automatic logic [NPORTS-1:0] port_bit(input logic [IW-1:0] idx);
    logic [NPORTS-1:0] m;
    for (int i = 0; i < NPORTS; i++) m[i] = (idx == IW'(i));
    return m;
  endfunction

  assign act  = carrier & ~jabber & ~partition;
  assign srcs = (IW+1)'($countones(act)) + (IW+1)'(casc_active);
  assign none = (srcs == '0);
  assign one  = (srcs == (IW+1)'(1));
  assign coll = (srcs > (IW+1)'(1)) || casc_col;

  always_comb begin
    sole = EXT;
    for (int i = NPORTS - 1; i >= 0; i--)
      if (act[i]) sole = IW'(i);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (coll) state_d = S_COLL;
               else if (one) state_d = S_RPT;
      S_RPT:   if (coll) state_d = S_COLL;
               else if (eb_error) state_d = S_NOISE;
               else if (none) state_d = S_IDLE;
      S_COLL:  if (!casc_col && none) state_d = S_IDLE;
               else if (!casc_col && one) state_d = S_OPL;
      S_OPL:   if (coll) state_d = S_COLL;
               else if (none) state_d = S_IDLE;
      S_NOISE: if (coll) state_d = S_COLL;
               else if (none) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state_q <= S_IDLE;
      n_q     <= '0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && state_d == S_RPT) n_q <= sole;
      if (state_q != S_OPL && state_d == S_OPL) left_q <= sole;
    end

  always_ff @(posedge clk)
    if (!rst_n) pol_q <= rxe_pol_pin;

  always_comb begin
    unique case (state_q)
      S_RPT:          tx_en = ~port_bit(n_q);
      S_OPL:          tx_en = ~port_bit(left_q);
      S_COLL, S_NOISE: tx_en = '1;
      default:        tx_en = '0;
    endcase
    tx_en = tx_en & ~jabber;
  end

  assign tx_ready   = |tx_en;
  assign state_code = state_q;
  assign rx_raw     = (state_q == S_RPT) ? port_bit(n_q) : '0;
  assign rx_en      = pol_q ? rx_raw : ~rx_raw;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase_q <= P_WAIT;
      pcnt_q  <= '0;
    end else if (state_q == S_IDLE) begin
      phase_q <= P_WAIT;
      pcnt_q  <= '0;
    end else begin
      case (phase_q)
        P_WAIT:
          if (!preamble_mode) phase_q <= P_DONE;
          else if (pcnt_q == CW'(PRE_DELAY - 1)) begin
            phase_q <= P_RUN;
            pcnt_q  <= '0;
          end else pcnt_q <= pcnt_q + 1'b1;
        P_RUN:
          if (pcnt_q == CW'(PRE_LEN)) phase_q <= P_DONE;
          else pcnt_q <= pcnt_q + 1'b1;
        default: phase_q <= P_DONE;
      endcase
    end

  always_comb begin
    if (phase_q == P_RUN) tx_sel = SRC_PRE;
    else if (phase_q == P_WAIT && preamble_mode) tx_sel = SRC_NONE;
    else if (state_q == S_IDLE) tx_sel = SRC_NONE;
    else if (state_q == S_RPT) tx_sel = SRC_DATA;
    else tx_sel = SRC_JAM;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) jam_q <= 1'b0;
    else jam_q <= (tx_sel == SRC_JAM) ? ~jam_q : 1'b0;

  always_comb
    unique case (tx_sel)
      SRC_PRE:  tx_nibble = (pcnt_q == CW'(PRE_LEN)) ? 4'hD : 4'h5;
      SRC_JAM:  tx_nibble = jam_q ? 4'h4 : 4'h3;
      default:  tx_nibble = 4'h0;
    endcase

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 4'd0) |-> (tx_en == '0 && !tx_ready));

  // R7
  rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code != 4'd3) |-> (rx_en == {NPORTS{~pol_q}}));

  // R3
  coll_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 4'd1) |-> &(tx_en | jabber));

  // R5
  opl_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 4'd2) |-> ($past(state_code) == 4'd1 || $past(state_code) == 4'd2));

  // R6
  noise_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 4'd4) |-> ($past(state_code) == 4'd3 || $past(state_code) == 4'd4));

  // R9
  jam_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sel == 2'd2 && $past(tx_sel) == 2'd2) |-> (tx_nibble != $past(tx_nibble)));

endmodule

// File: tb/repeater_core_bench.sv
`timescale 1ns/1ps
module repeater_core_bench;
  localparam int NP = 4, PD = 12, PL = 15;

  logic clk = 0, rst_n = 0, pol_pin = 1, pmode = 0;
  logic [NP-1:0] carrier = 0, jabber = 0, partition = 0;
  logic casc_active = 0, casc_col = 0, eb_error = 0;
  logic [NP-1:0] rx_en, tx_en;
  logic tx_ready;
  logic [3:0] state_code, tx_nibble;
  logic [1:0] tx_sel;

  int errors = 0, checks = 0;
  bit done = 0;

  // model registers
  int m_state = 0, m_n = 0, m_left = 0, m_phase = 0, m_pcnt = 0;
  bit m_pol = 1, m_jam = 0;

  always #2.5 clk = ~clk;

  repeater_core #(.NPORTS(NP), .PRE_DELAY(PD), .PRE_LEN(PL)) u_repeater_core (
    .clk(clk), .rst_n(rst_n), .rxe_pol_pin(pol_pin), .preamble_mode(pmode),
    .carrier(carrier), .jabber(jabber), .partition(partition),
    .casc_active(casc_active), .casc_col(casc_col), .eb_error(eb_error),
    .rx_en(rx_en), .tx_en(tx_en), .tx_ready(tx_ready), .state_code(state_code),
    .tx_sel(tx_sel), .tx_nibble(tx_nibble));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int srcs();
    logic [NP-1:0] a = carrier & ~jabber & ~partition;
    return $countones(a) + int'(casc_active);
  endfunction

  function automatic int sole();
    logic [NP-1:0] a = carrier & ~jabber & ~partition;
    for (int i = 0; i < NP; i++) if (a[i]) return i;
    return NP;
  endfunction

  function automatic logic [NP-1:0] e_tx();
    logic [NP-1:0] m;
    case (m_state)
      3: m = ~(NP'(1) << m_n);
      2: m = ~(NP'(1) << m_left);
      1, 4: m = '1;
      default: m = '0;
    endcase
    if (m_state == 3 && m_n >= NP) m = '1;
    if (m_state == 2 && m_left >= NP) m = '1;
    return m & ~jabber;
  endfunction

  function automatic int e_sel();
    if (m_phase == 1) return 3;
    if (m_phase == 0 && pmode) return 0;
    if (m_state == 0) return 0;
    if (m_state == 3) return 1;
    return 2;
  endfunction

  function automatic int e_nib();
    int s = e_sel();
    if (s == 3) return (m_pcnt == PL) ? 'hD : 5;
    if (s == 2) return m_jam ? 4 : 3;
    return 0;
  endfunction

  function automatic logic [NP-1:0] e_rx();
    logic [NP-1:0] r = (m_state == 3 && m_n < NP) ? (NP'(1) << m_n) : '0;
    return m_pol ? r : ~r;
  endfunction

  task automatic model_step();
    int s = srcs();
    bit cl = (s > 1) || casc_col;
    int nx = m_state, sel = e_sel();
    case (m_state)
      0: if (cl) nx = 1; else if (s == 1) nx = 3;
      3: if (cl) nx = 1; else if (eb_error) nx = 4; else if (s == 0) nx = 0;
      1: if (!casc_col && s == 0) nx = 0; else if (!casc_col && s == 1) nx = 2;
      default: if (cl) nx = 1; else if (s == 0) nx = 0;
    endcase
    if (m_state == 0) begin m_phase = 0; m_pcnt = 0; end
    else if (m_phase == 0) begin
      if (!pmode) m_phase = 2;
      else if (m_pcnt == PD - 1) begin m_phase = 1; m_pcnt = 0; end
      else m_pcnt++;
    end else if (m_phase == 1) begin
      if (m_pcnt == PL) m_phase = 2; else m_pcnt++;
    end
    m_jam = (sel == 2) ? ~m_jam : 0;
    if (m_state == 0 && nx == 3) m_n = sole();
    if (m_state != 2 && nx == 2) m_left = sole();
    m_state = nx;
  endtask

  task automatic compare_all();
    chk("R4 state", state_code, m_state);
    chk("R2 tx_en", tx_en, e_tx());
    chk("R7 rx_en", rx_en, e_rx());
    chk("R11 tx_ready", tx_ready, |e_tx());
    chk("R11 tx_sel", tx_sel, e_sel());
    chk("R9 tx_nibble", tx_nibble, e_nib());
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset(bit p);
    @(negedge clk);
    rst_n = 0; pol_pin = p;
    carrier = 0; jabber = 0; partition = 0;
    casc_active = 0; casc_col = 0; eb_error = 0;
    repeat (3) @(posedge clk);
    m_state = 0; m_n = 0; m_left = 0; m_phase = 0; m_pcnt = 0; m_jam = 0; m_pol = p;
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset(1);
    // R1 reset state
    chk("R1 state", state_code, 0);
    chk("R1 tx_en", tx_en, 0);
    chk("R1 tx_sel", tx_sel, 0);
    chk("R1 nibble", tx_nibble, 0);
    chk("R7 rx_en idle high-pol", rx_en, 0);

    // R2 repeat on port 2
    carrier = 4'b0100; tick();
    chk("R2 state", state_code, 3);
    chk("R2 tx_en", tx_en, 4'b1011);
    chk("R7 rx_en", rx_en, 4'b0100);
    chk("R11 sel data", tx_sel, 1);
    // R3 collision + R9 jam
    carrier = 4'b0110; tick();
    chk("R3 state", state_code, 1);
    chk("R3 tx_en", tx_en, 4'b1111);
    chk("R9 jam first", tx_nibble, 3);
    tick();
    chk("R9 jam second", tx_nibble, 4);
    // R5 one port left on port 1
    carrier = 4'b0010; tick();
    chk("R5 state", state_code, 2);
    chk("R5 tx_en", tx_en, 4'b1101);
    carrier = 4'b1010; tick();
    chk("R5 back to collision", state_code, 1);
    carrier = 4'b0000; tick();
    chk("R4 idle", state_code, 0);
    chk("R11 tx_ready idle", tx_ready, 0);

    // R8 masking
    partition = 4'b0001; carrier = 4'b0101; tick();
    chk("R8 partitioned ignored", state_code, 3);
    chk("R8 rx on port2", rx_en, 4'b0100);
    jabber = 4'b0010; tick();
    chk("R8 jabber tx cut", tx_en, 4'b1001);
    carrier = 0; partition = 0; jabber = 0; tick();

    // R6 noise
    carrier = 4'b0100; tick();
    eb_error = 1; tick();
    eb_error = 0;
    chk("R6 noise state", state_code, 4);
    chk("R6 noise tx_en", tx_en, 4'b1111);
    chk("R6 noise jam", tx_sel, 2);
    casc_col = 1; tick(); casc_col = 0;
    chk("R6 noise to collision", state_code, 1);
    carrier = 0; tick(); tick();

    // cascade-only source: repeat enabling all ports
    casc_active = 1; tick();
    chk("R2 cascade repeat", tx_en, 4'b1111);
    casc_active = 0; tick();

    // R10 preamble regeneration with collision mid-way
    pmode = 1; carrier = 4'b0001; tick();
    chk("R10 wait none", tx_sel, 0);
    for (int k = 2; k <= PD; k++) tick();
    chk("R10 still waiting", tx_sel, 0);
    tick();
    chk("R10 preamble start", tx_sel, 3);
    chk("R10 preamble five", tx_nibble, 5);
    carrier = 4'b0011; tick();
    chk("R10 collision state", state_code, 1);
    chk("R10 preamble kept", tx_sel, 3);
    for (int k = 0; k < PL - 2; k++) tick();
    chk("R10 last five", tx_nibble, 5);
    tick();
    chk("R10 sfd nibble", tx_nibble, 'hD);
    tick();
    chk("R10 then jam", tx_sel, 2);
    chk("R9 jam starts at 3", tx_nibble, 3);
    carrier = 0; tick(); tick();

    // random phase
    for (int c = 0; c < 6000; c++) begin
      if (c % 700 == 0) pmode = $urandom_range(0, 1);
      if ($urandom_range(0, 5) == 0) begin
        int p = $urandom_range(0, NP - 1);
        if (carrier[p] || $urandom_range(0, 2) == 0) carrier[p] = ~carrier[p];
      end
      if ($urandom_range(0, 39) == 0) carrier = 0;
      if ($urandom_range(0, 47) == 0) casc_active = ~casc_active;
      casc_col = ($urandom_range(0, 63) == 0);
      eb_error = ($urandom_range(0, 31) == 0);
      if ($urandom_range(0, 149) == 0) jabber[$urandom_range(0, NP - 1)] ^= 1'b1;
      if ($urandom_range(0, 149) == 0) partition[$urandom_range(0, NP - 1)] ^= 1'b1;
      tick();
    end

    // R7 active-low polarity
    pmode = 0;
    do_reset(0);
    chk("R7 idle low-pol", rx_en, 4'b1111);
    carrier = 4'b1000; tick();
    chk("R7 low-pol port3", rx_en, 4'b0111);
    carrier = 0; tick();
    chk("R7 low-pol back idle", rx_en, 4'b1111);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule